// File: doc/BRIEF.md
# SPI Framed Register-Access Slave

This block is an SPI slave that turns framed serial commands into byte reads and writes on a local synchronous memory port. Each frame opens with a four-byte header that carries a start address, a transfer direction and a byte count. Data bytes follow within the same chip-select window. A write frame stores each received byte at the next address. A read frame fetches bytes from consecutive addresses and shifts them back to the master. Because the count travels in the header, one frame can move a burst of any length up to 32767 bytes.

The SPI pins are brought into the system clock domain through two-flop synchronizers, and all logic runs on `clk_i`. SCLK must therefore be slow against `clk_i`: one SCLK half period must cover about eight system cycles. The memory port issues single-cycle strobes. Read data is expected one cycle after the read strobe.

Top module: `spi_frame_slave`

## Requirements
- R1: Header bytes arrive in this order. Byte 0 is address[15:8] and byte 1 is address[7:0]. In byte 2, bit 7 is the direction (1 = write, 0 = read) and bits 6:0 are count[14:8]. Byte 3 is count[7:0]. Every bit of the count, the high bits included, sets the frame length.
- R2: In a write frame, each data byte after the header produces one `mem_we_o` pulse carrying that byte. The first pulse uses the header address and each later pulse uses the next address.
- R3: In a read frame, the slave fetches from consecutive addresses starting at the header address with one `mem_re_o` pulse per byte. It returns each byte on MISO, MSB first, during the data byte that follows the header or the previous data byte.
- R4: A count of 2 returns the byte at the lower address first, so a 16-bit value stored high byte first is read big-endian.
- R5: The address wraps from 0xFFFF to 0x0000 within a burst.
- R6: A count of 0 causes no memory access, whatever bytes follow.
- R7: Bytes sent after the count is used up cause no memory access, and MISO stays 0 during them.
- R8: Raising CS_n ends the frame at once, even if fewer bytes than the count have moved. The next CS_n assertion starts a fresh header.
- R9: SPI mode 0 is used. MOSI is sampled on the rising SCLK edge, and MISO changes after the falling edge.
- R10: MISO is 0 outside the data phase of a read frame: in the header, in write frames, and while CS_n is high.
- R11: `mem_we_o` and `mem_re_o` are single-cycle pulses that are never high together. `mem_addr_o` changes only in a cycle with a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock from master |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after `mem_re_o` |

## Verification
An SCLK edge is recognised two system cycles after it reaches the pin. A byte is complete one cycle later, and the memory strobe for it follows one cycle after that. Read data is captured two cycles after the strobe and appears on MISO only after the next falling SCLK edge. The bench holds each SCLK half period for ten system cycles and samples MISO just before it raises SCLK, so every result has settled well before it is observed. Strobe counts and the last write address are read only after CS_n has been high for twenty cycles, by which time every pulse of the frame has occurred.

// File: rtl/spi_frame_pkg.sv
`timescale 1ns/100ps
package spi_frame_pkg;
  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_frame_sync.sv
`timescale 1ns/100ps
module spi_frame_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/spi_frame_shift.sv
`timescale 1ns/100ps
module spi_frame_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic              tx_en_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              miso_o
);
  localparam int CW = $clog2(BYTE_W);

  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic [BYTE_W-1:0] rx_nxt;

  assign rx_nxt = {rx_sh[BYTE_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      rx_byte_o   <= '0;
      byte_done_o <= 1'b0;
    end else if (!active_i) begin
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      byte_done_o <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      if (rise_i) begin
        rx_sh <= rx_nxt;
        if (bit_cnt == CW'(BYTE_W - 1)) begin
          bit_cnt     <= '0;
          byte_done_o <= 1'b1;
          rx_byte_o   <= rx_nxt;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      // falling edge: load a fresh byte at a boundary, else shift
      if (fall_i) begin
        if (!tx_en_i)          tx_sh <= '0;
        else if (bit_cnt == '0) tx_sh <= tx_byte_i;
        else                   tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o = tx_en_i & tx_sh[BYTE_W-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/100ps
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 15,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              tx_en_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  localparam int HDR_W = ADDR_W + 1 + CNT_W;
  localparam int HDR_N = HDR_W / BYTE_W;
  localparam int HIW   = $clog2(HDR_N);

  phase_e              phase;
  logic [HIW-1:0]      hdr_idx;
  logic [HDR_W-BYTE_W-1:0] hdr_sh;
  logic [HDR_W-1:0]    hdr_word;
  logic [ADDR_W-1:0]   addr_q, addr_nxt, hdr_addr;
  logic [CNT_W-1:0]    rem_q, hdr_cnt;
  logic                wr_q, hdr_wr, rd_pend;

  assign hdr_word = {hdr_sh, rx_byte_i};
  assign hdr_addr = hdr_word[HDR_W-1 -: ADDR_W];
  assign hdr_wr   = hdr_word[CNT_W];
  assign hdr_cnt  = hdr_word[CNT_W-1:0];
  assign addr_nxt = addr_q + 1'b1;
  assign tx_en_o  = (phase == PH_DATA) && !wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase       <= PH_HDR;
      hdr_idx     <= '0;
      hdr_sh      <= '0;
      addr_q      <= '0;
      rem_q       <= '0;
      wr_q        <= 1'b0;
      rd_pend     <= 1'b0;
      tx_byte_o   <= '0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_we_o    <= 1'b0;
      mem_re_o    <= 1'b0;
    end else begin
      mem_we_o <= 1'b0;
      mem_re_o <= 1'b0;
      rd_pend  <= mem_re_o;
      if (rd_pend) tx_byte_o <= mem_rdata_i;
      if (!active_i) begin
        phase   <= PH_HDR;
        hdr_idx <= '0;
      end else if (byte_done_i) begin
        unique case (phase)
          PH_HDR: begin
            hdr_sh <= hdr_word[HDR_W-BYTE_W-1:0];
            if (hdr_idx == HIW'(HDR_N - 1)) begin
              hdr_idx <= '0;
              addr_q  <= hdr_addr;
              wr_q    <= hdr_wr;
              rem_q   <= hdr_cnt;
              if (hdr_cnt == '0) begin
                phase <= PH_DONE;
              end else begin
                phase <= PH_DATA;
                if (!hdr_wr) begin  // prefetch first read byte
                  mem_re_o   <= 1'b1;
                  mem_addr_o <= hdr_addr;
                end
              end
            end else begin
              hdr_idx <= hdr_idx + 1'b1;
            end
          end
          PH_DATA: begin
            addr_q <= addr_nxt;
            rem_q  <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1)) phase <= PH_DONE;
            if (wr_q) begin
              mem_we_o    <= 1'b1;
              mem_addr_o  <= addr_q;
              mem_wdata_o <= rx_byte_i;
            end else if (rem_q != CNT_W'(1)) begin
              mem_re_o   <= 1'b1;
              mem_addr_o <= addr_nxt;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_frame_slave.sv
`timescale 1ns/100ps
module spi_frame_slave #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 15,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  logic [2:0]        pin_s;
  logic              sclk_s, cs_s, mosi_s, sclk_q;
  logic              rise, fall, active;
  logic              byte_done, tx_en;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  spi_frame_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   (pin_s)
  );
  assign {sclk_s, cs_s, mosi_s} = pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s;
  end

  assign rise   = sclk_s & ~sclk_q;
  assign fall   = ~sclk_s & sclk_q;
  assign active = ~cs_s;

  spi_frame_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .rise_i     (rise),
    .fall_i     (fall),
    .mosi_i     (mosi_s),
    .tx_en_i    (tx_en),
    .tx_byte_i  (tx_byte),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte),
    .miso_o     (miso_o)
  );

  spi_frame_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .byte_done_i(byte_done),
    .rx_byte_i  (rx_byte),
    .tx_en_o    (tx_en),
    .tx_byte_o  (tx_byte),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .mem_rdata_i(mem_rdata_i)
  );
endmodule

// File: rtl/spi_frame_chk.sv
`timescale 1ns/100ps
module spi_frame_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              miso_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic [2:0] cs_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cs_hi_cnt <= '0;
    else if (!cs_ni)             cs_hi_cnt <= '0;
    else if (cs_hi_cnt != 3'd7)  cs_hi_cnt <= cs_hi_cnt + 1'b1;
  end

  // R11
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R11
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  // R11
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o || mem_re_o) |-> $stable(mem_addr_o));

  // R10
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_hi_cnt >= 3'd4) |-> !miso_o);
endmodule

bind spi_frame_slave spi_frame_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .miso_o    (miso_o),
  .mem_we_o  (mem_we_o),
  .mem_re_o  (mem_re_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/sim_spi_frame_slave.sv
`timescale 1ns/100ps
module sim_spi_frame_slave;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, we, re;
  logic [15:0] addr;
  logic [7:0]  wdata, rdata;

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  int          we_cnt = 0, re_cnt = 0;
  logic [15:0] last_waddr = '0;

  logic [7:0]  txb [32];
  logic [7:0]  rxb [32];
  int          errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  spi_frame_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we),
    .mem_re_o(re), .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (we) begin
      mem[addr[7:0]] <= wdata;
      we_cnt         <= we_cnt + 1;
      last_waddr     <= addr;
    end
    if (re) begin
      rdata  <= mem[addr[7:0]];
      re_cnt <= re_cnt + 1;
    end
  end

  function automatic logic [7:0] seed(input logic [7:0] a);
    return a * 8'd7 + 8'd3;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic hdr(input logic [15:0] a, input logic w, input logic [14:0] c);
    txb[0] = a[15:8];
    txb[1] = a[7:0];
    txb[2] = {w, c[14:8]};
    txb[3] = c[7:0];
  endtask

  // mode 0: master sets MOSI, samples MISO, then raises SCLK
  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      #50;
      rx[i] = miso;
      sclk = 1'b1;
      #50;
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input int n);
    logic [7:0] r;
    cs_n = 1'b0;
    #50;
    for (int i = 0; i < n; i++) begin
      xbyte(txb[i], r);
      rxb[i] = r;
    end
    #50;
    cs_n = 1'b1;
    mosi = 1'b0;
    #100;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #750000;
    errors++;
    checks++;
    $display("FAIL watchdog: got 0x1 expected 0x0");
    summary();
  end

  initial begin
    int w0, r0;
    logic [15:0] a;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = seed(8'(i));
      exp_mem[i] = seed(8'(i));
    end
    #23;
    chk("R10 miso in reset", int'(miso), 0);
    chk("R11 strobes in reset", int'({we, re}), 0);
    rst_n = 1'b1;
    #100;

    // R1 R3 R9: single byte reads at scattered addresses
    for (int k = 0; k < 8; k++) begin
      a = {8'(k * 37), 8'(k * 29 + 5)};
      hdr(a, 1'b0, 15'd1);
      txb[4] = 8'hFF;
      frame(5);
      chk("R3 single read", int'(rxb[4]), int'(exp_mem[a[7:0]]));
      chk("R10 miso in header", int'(rxb[0] | rxb[1] | rxb[2] | rxb[3]), 0);
    end

    // R4: 16-bit read, lower address first
    hdr(16'h0030, 1'b0, 15'd2);
    frame(6);
    chk("R4 16-bit read", int'({rxb[4], rxb[5]}),
        int'({exp_mem[8'h30], exp_mem[8'h31]}));

    // R3 R7: burst reads of several lengths, one surplus byte each
    for (int c = 1; c <= 6; c++) begin
      a  = 16'h0050 + 16'(c * 8);
      hdr(a, 1'b0, 15'(c));
      r0 = re_cnt;
      frame(5 + c);
      chk("R3 read strobes", re_cnt - r0, c);
      for (int i = 0; i < c; i++)
        chk("R3 burst byte", int'(rxb[4 + i]), int'(exp_mem[8'(a + 16'(i))]));
      chk("R7 miso after count", int'(rxb[4 + c]), 0);
    end

    // R2 R7: write burst of 5 with 2 surplus bytes
    hdr(16'h0080, 1'b1, 15'd5);
    for (int i = 0; i < 7; i++) txb[4 + i] = 8'hA0 + 8'(i);
    w0 = we_cnt;
    frame(11);
    for (int i = 0; i < 5; i++) exp_mem[8'h80 + 8'(i)] = 8'hA0 + 8'(i);
    chk("R2 R7 write strobes", we_cnt - w0, 5);
    chk("R2 last write address", int'(last_waddr), 16'h0084);
    chk("R10 miso in write frame", int'(rxb[4] | rxb[6] | rxb[10]), 0);
    hdr(16'h0080, 1'b0, 15'd7);
    frame(11);
    for (int i = 0; i < 7; i++)
      chk("R2 write readback", int'(rxb[4 + i]), int'(exp_mem[8'h80 + 8'(i)]));

    // R5: address wrap on write and read
    hdr(16'hFFFF, 1'b1, 15'd2);
    txb[4] = 8'h11;
    txb[5] = 8'h22;
    w0 = we_cnt;
    frame(6);
    exp_mem[8'hFF] = 8'h11;
    exp_mem[8'h00] = 8'h22;
    chk("R5 wrap write strobes", we_cnt - w0, 2);
    chk("R5 wrapped address", int'(last_waddr), 0);
    hdr(16'hFFFF, 1'b0, 15'd2);
    frame(6);
    chk("R5 wrap read", int'({rxb[4], rxb[5]}), 16'h1122);

    // R6: zero count, write and read
    hdr(16'h0090, 1'b1, 15'd0);
    txb[4] = 8'h5A; txb[5] = 8'h5A; txb[6] = 8'h5A;
    w0 = we_cnt;
    frame(7);
    chk("R6 zero-count writes", we_cnt - w0, 0);
    hdr(16'h0090, 1'b0, 15'd0);
    r0 = re_cnt;
    frame(6);
    chk("R6 zero-count reads", re_cnt - r0, 0);
    chk("R6 zero-count miso", int'(rxb[4] | rxb[5]), 0);
    hdr(16'h0090, 1'b0, 15'd1);
    frame(5);
    chk("R6 target unchanged", int'(rxb[4]), int'(exp_mem[8'h90]));

    // R8: CS raised after 2 of 4 bytes, next frame decodes fresh header
    hdr(16'h00C0, 1'b1, 15'd4);
    txb[4] = 8'h31;
    txb[5] = 8'h32;
    w0 = we_cnt;
    frame(6);
    exp_mem[8'hC0] = 8'h31;
    exp_mem[8'hC1] = 8'h32;
    chk("R8 early end writes", we_cnt - w0, 2);
    hdr(16'h00C0, 1'b0, 15'd4);
    frame(8);
    for (int i = 0; i < 4; i++)
      chk("R8 fresh frame read", int'(rxb[4 + i]), int'(exp_mem[8'hC0 + 8'(i)]));

    // R1: count with high bits only, ended early by CS
    hdr(16'h00D0, 1'b0, 15'h0100);
    r0 = re_cnt;
    frame(7);
    chk("R1 high count bits prefetch", re_cnt - r0, 4);
    for (int i = 0; i < 3; i++)
      chk("R1 high count data", int'(rxb[4 + i]), int'(exp_mem[8'hD0 + 8'(i)]));

    chk("R10 miso idle", int'(miso), 0);
    summary();
  end
endmodule